// File: doc/BRIEF.md
# Double-Buffered Info Packet Store

This block holds fifteen generic info packets for a video transmitter. Each packet slot is nine 32-bit words: one header word followed by eight payload words. Software reaches all slots through one word-index register and one data port. Each data write stores the word at the current index and then advances the index, so a whole packet is loaded by setting the index to `slot * 9` and writing nine words in a row.

Every slot has two copies. Software writes only the shadow copy. The transmit side only ever reads the active copy. Software marks a slot for update by setting that slot's bit in an update-request mask. At the next block-update pulse, and only while the update lock input is low, all nine shadow words of every marked slot are copied to active in one clock, and those request bits clear.

A sticky conflict flag records any data write that lands on a slot which, in the same cycle, is being read by the transmit side or committed. A write-one-to-clear input resets the flag.

Top module: `pkt_store`

## Requirements
- R1: After reset the index is 0, no update request is pending, the conflict flag is 0, and every active word reads back as zero.
- R2: `sw_idx_we` loads `sw_idx_wdata` into the index. When it coincides with a data write, the write uses the old index, and the loaded value wins over the increment.
- R3: A data write with index below 135 stores `sw_data_wdata` into shadow word `index` (slot `index / 9`, word `index % 9`) and adds one to the index.
- R4: A data write while the index is 135 or above, which means slot 15 or higher, changes no slot and leaves the index unchanged.
- R5: Word `slot*9` is the header, with header byte 0 in bits 7:0, byte 1 in 15:8, byte 2 in 23:16 and byte 3 in 31:24. Words `slot*9+1` to `slot*9+8` hold payload words 0 to 7, and each is returned unchanged by the read port.
- R6: A shadow write is not visible at the read port until that slot has been committed.
- R7: `sw_upd_we` ORs `sw_upd_wdata` (bit s = slot s) into the pending mask. A cycle with `blk_upd`=1 and `upd_lock`=0 copies all nine words of every pending slot to active and clears those pending bits. A request made in that same cycle stays pending.
- R8: While `upd_lock` is 1, or when no `blk_upd` pulse arrives, pending bits stay set and the active words are unchanged.
- R9: `hw_rd_data` updates one clock after a cycle with `hw_rd_en`=1, returning active word `hw_rd_word` of slot `hw_rd_slot`. It returns 0 when the slot is above 14 or the word is above 8, holds its value while `hw_rd_en` is 0, and a read in a commit cycle returns the pre-commit value.
- R10: The conflict flag sets when a valid data write targets slot s while, in the same cycle, `hw_rd_en` reads slot s or slot s is being committed. It stays set until `sw_conf_clr`. If a new conflict arrives in the same cycle as the clear, the flag stays set.
- R11: A commit copies the shadow contents as they stood before a data write in the same cycle. That write lands in the shadow copy only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_idx_we | input | 1 | Load word index |
| sw_idx_wdata | input | 8 | New word index |
| sw_data_we | input | 1 | Data port write strobe |
| sw_data_wdata | input | 32 | Data port write word |
| sw_upd_we | input | 1 | Write update-request mask |
| sw_upd_wdata | input | 15 | Update-request bits, one per slot |
| sw_conf_clr | input | 1 | Write-one-to-clear of conflict flag |
| blk_upd | input | 1 | Block-update event pulse |
| upd_lock | input | 1 | Update lock level; blocks commits when 1 |
| hw_rd_en | input | 1 | Transmit-side read enable |
| hw_rd_slot | input | 4 | Transmit-side slot number |
| hw_rd_word | input | 4 | Transmit-side word within slot |
| sw_idx | output | 8 | Current word index |
| sw_upd_pend | output | 15 | Pending update requests |
| conflict | output | 1 | Sticky write/read conflict flag |
| hw_rd_data | output | 32 | Registered active-copy read data |

## Verification
A wrong shadow word only shows at the ports after that slot's next commit and a read of the word. Commits are therefore followed by full slot read-backs. A stale or early commit shows on the read port within one clock of the read, and a wrongly kept or dropped request shows on `sw_upd_pend` in the very next cycle. Index and conflict errors surface on their outputs one clock after the offending write, and the reference model compares these every cycle.

// File: rtl/pkt_store_pkg.sv
package pkt_store_pkg;
  localparam int unsigned DEF_SLOTS = 15;
  localparam int unsigned DEF_WORDS = 9;
  localparam int unsigned DEF_DW    = 32;

  // Word index of the first word of a slot.
  function automatic int unsigned slot_base(input int unsigned slot, input int unsigned words);
    return slot * words;
  endfunction
endpackage

// File: rtl/pkt_index_ctrl.sv
module pkt_index_ctrl #(
  parameter int unsigned NSLOT = 15,
  parameter int unsigned NWORD = 9,
  parameter int unsigned IDXW  = 8,
  parameter int unsigned SLW   = 4,
  parameter int unsigned WW    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld,
  input  logic [IDXW-1:0] ld_val,
  input  logic            adv,
  output logic [IDXW-1:0] idx,
  output logic            in_range,
  output logic [SLW-1:0]  slot,
  output logic [WW-1:0]   word
);
  import pkt_store_pkg::*;
  localparam int unsigned TOTAL = NSLOT * NWORD;

  logic [IDXW-1:0] idx_q, idx_d;
  logic            idx_en;

  always_comb begin
    in_range = (idx_q < IDXW'(TOTAL));
    slot     = '0;
    word     = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (idx_q >= IDXW'(slot_base(s, NWORD))) begin
        slot = SLW'(s);
        word = WW'(idx_q - IDXW'(slot_base(s, NWORD)));
      end
    end
  end

  always_comb begin
    idx_en = ld | (adv & in_range);
    idx_d  = ld ? ld_val : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx = idx_q;
endmodule

// File: rtl/pkt_commit_ctrl.sv
module pkt_commit_ctrl #(
  parameter int unsigned NSLOT = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_we,
  input  logic [NSLOT-1:0] req_bits,
  input  logic             blk_upd,
  input  logic             lock,
  output logic [NSLOT-1:0] pend,
  output logic [NSLOT-1:0] commit
);
  logic [NSLOT-1:0] pend_q, pend_d;
  logic             fire, pend_en;

  always_comb begin
    fire    = blk_upd & ~lock;
    commit  = pend_q & {NSLOT{fire}};
    pend_en = fire | req_we;
    pend_d  = (pend_q & ~commit) | (req_bits & {NSLOT{req_we}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/pkt_slot.sv
module pkt_slot #(
  parameter int unsigned NWORD = 9,
  parameter int unsigned DW    = 32,
  parameter int unsigned WW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WW-1:0]       wr_word,
  input  logic [DW-1:0]       wr_data,
  input  logic                commit,
  output logic [NWORD*DW-1:0] act_flat
);
  logic [DW-1:0] sh_q [NWORD];
  logic [DW-1:0] ac_q [NWORD];
  logic [NWORD-1:0] sh_en;

  always_comb begin
    for (int w = 0; w < NWORD; w++) sh_en[w] = wr_en && (wr_word == WW'(w));
  end

  genvar g;
  generate
    for (g = 0; g < NWORD; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sh_q[g] <= '0;
        else if (sh_en[g]) sh_q[g] <= wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ac_q[g] <= '0;
        else if (commit) ac_q[g] <= sh_q[g];
      end
      assign act_flat[g*DW +: DW] = ac_q[g];
    end
  endgenerate
endmodule

// File: rtl/pkt_store.sv
module pkt_store #(
  parameter int unsigned NSLOT = pkt_store_pkg::DEF_SLOTS,
  parameter int unsigned NWORD = pkt_store_pkg::DEF_WORDS,
  parameter int unsigned DW    = pkt_store_pkg::DEF_DW,
  localparam int unsigned IDXW = $clog2(NSLOT * NWORD + 1),
  localparam int unsigned SLW  = $clog2(NSLOT + 1),
  localparam int unsigned WW   = $clog2(NWORD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_idx_we,
  input  logic [IDXW-1:0]  sw_idx_wdata,
  input  logic             sw_data_we,
  input  logic [DW-1:0]    sw_data_wdata,
  input  logic             sw_upd_we,
  input  logic [NSLOT-1:0] sw_upd_wdata,
  input  logic             sw_conf_clr,
  input  logic             blk_upd,
  input  logic             upd_lock,
  input  logic             hw_rd_en,
  input  logic [SLW-1:0]   hw_rd_slot,
  input  logic [WW-1:0]    hw_rd_word,
  output logic [IDXW-1:0]  sw_idx,
  output logic [NSLOT-1:0] sw_upd_pend,
  output logic             conflict,
  output logic [DW-1:0]    hw_rd_data
);
  logic            in_range, wr_ok;
  logic [SLW-1:0]  wslot;
  logic [WW-1:0]   wword;
  logic [NSLOT-1:0] commit;
  logic [NWORD*DW-1:0] act_all [NSLOT];

  pkt_index_ctrl #(.NSLOT(NSLOT), .NWORD(NWORD), .IDXW(IDXW), .SLW(SLW), .WW(WW)) u_idx (
    .clk(clk), .rst_n(rst_n), .ld(sw_idx_we), .ld_val(sw_idx_wdata), .adv(sw_data_we),
    .idx(sw_idx), .in_range(in_range), .slot(wslot), .word(wword)
  );

  assign wr_ok = sw_data_we & in_range;

  pkt_commit_ctrl #(.NSLOT(NSLOT)) u_cmt (
    .clk(clk), .rst_n(rst_n), .req_we(sw_upd_we), .req_bits(sw_upd_wdata),
    .blk_upd(blk_upd), .lock(upd_lock), .pend(sw_upd_pend), .commit(commit)
  );

  genvar s;
  generate
    for (s = 0; s < NSLOT; s++) begin : g_slot
      pkt_slot #(.NWORD(NWORD), .DW(DW), .WW(WW)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_ok && (wslot == SLW'(s))),
        .wr_word(wword), .wr_data(sw_data_wdata),
        .commit(commit[s]), .act_flat(act_all[s])
      );
    end
  endgenerate

  // Transmit-side read: registered, active copy only
  logic [DW-1:0] rd_d, rd_q;
  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NSLOT; i++)
      for (int w = 0; w < NWORD; w++)
        if (hw_rd_slot == SLW'(i) && hw_rd_word == WW'(w)) rd_d = act_all[i][w*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_q <= '0;
    else if (hw_rd_en) rd_q <= rd_d;
  end
  assign hw_rd_data = rd_q;

  // Conflict detection: set has priority over clear
  logic hit, conf_q, conf_d, conf_en;
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NSLOT; i++)
      if (wslot == SLW'(i) && ((hw_rd_en && hw_rd_slot == SLW'(i)) || commit[i])) hit = 1'b1;
    hit     = hit & wr_ok;
    conf_en = hit | sw_conf_clr;
    conf_d  = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       conf_q <= 1'b0;
    else if (conf_en) conf_q <= conf_d;
  end
  assign conflict = conf_q;
endmodule

// File: rtl/pkt_store_chk.sv
module pkt_store_chk #(
  parameter int unsigned NSLOT = 15,
  parameter int unsigned NWORD = 9,
  parameter int unsigned DW    = 32,
  parameter int unsigned IDXW  = 8,
  parameter int unsigned SLW   = 4,
  parameter int unsigned WW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_idx_we,
  input logic             sw_data_we,
  input logic             sw_upd_we,
  input logic             sw_conf_clr,
  input logic             blk_upd,
  input logic             upd_lock,
  input logic             hw_rd_en,
  input logic [SLW-1:0]   hw_rd_slot,
  input logic [IDXW-1:0]  sw_idx,
  input logic [NSLOT-1:0] sw_upd_pend,
  input logic             conflict,
  input logic [DW-1:0]    hw_rd_data
);
  localparam int unsigned TOTAL = NSLOT * NWORD;

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_data_we && !sw_idx_we && sw_idx < IDXW'(TOTAL)) |=> sw_idx == IDXW'($past(sw_idx) + 1'b1)); // R3
  AST_IDX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_idx_we && sw_idx >= IDXW'(TOTAL)) |=> $stable(sw_idx)); // R4
  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_lock || !blk_upd) |=> ((sw_upd_pend & $past(sw_upd_pend)) == $past(sw_upd_pend))); // R8
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_upd && !upd_lock && !sw_upd_we) |=> sw_upd_pend == '0); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_rd_en |=> $stable(hw_rd_data)); // R9
  AST_RD_BADSLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_rd_en && hw_rd_slot >= SLW'(NSLOT)) |=> hw_rd_data == '0); // R9
  AST_CONF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && !sw_conf_clr) |=> conflict); // R10
  AST_CONF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_conf_clr && !sw_data_we) |=> !conflict); // R10
endmodule

bind pkt_store pkt_store_chk #(
  .NSLOT(NSLOT), .NWORD(NWORD), .DW(DW), .IDXW(IDXW), .SLW(SLW), .WW(WW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sw_idx_we(sw_idx_we), .sw_data_we(sw_data_we),
  .sw_upd_we(sw_upd_we), .sw_conf_clr(sw_conf_clr), .blk_upd(blk_upd), .upd_lock(upd_lock),
  .hw_rd_en(hw_rd_en), .hw_rd_slot(hw_rd_slot), .sw_idx(sw_idx), .sw_upd_pend(sw_upd_pend),
  .conflict(conflict), .hw_rd_data(hw_rd_data)
);

// File: tb/pkt_store_tb_top.sv
`timescale 1ns/1ps
module pkt_store_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_idx_we, sw_data_we, sw_upd_we, sw_conf_clr, blk_upd, upd_lock, hw_rd_en;
  logic [7:0]  sw_idx_wdata;
  logic [31:0] sw_data_wdata;
  logic [14:0] sw_upd_wdata;
  logic [3:0]  hw_rd_slot, hw_rd_word;
  logic [7:0]  sw_idx;
  logic [14:0] sw_upd_pend;
  logic        conflict;
  logic [31:0] hw_rd_data;

  always #2.5 clk = ~clk;

  pkt_store dut_i (
    .clk(clk), .rst_n(rst_n), .sw_idx_we(sw_idx_we), .sw_idx_wdata(sw_idx_wdata),
    .sw_data_we(sw_data_we), .sw_data_wdata(sw_data_wdata), .sw_upd_we(sw_upd_we),
    .sw_upd_wdata(sw_upd_wdata), .sw_conf_clr(sw_conf_clr), .blk_upd(blk_upd),
    .upd_lock(upd_lock), .hw_rd_en(hw_rd_en), .hw_rd_slot(hw_rd_slot), .hw_rd_word(hw_rd_word),
    .sw_idx(sw_idx), .sw_upd_pend(sw_upd_pend), .conflict(conflict), .hw_rd_data(hw_rd_data)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  string tag = "R1";

  // Behavioural reference model
  logic [31:0] m_sh [135];
  logic [31:0] m_ac [135];
  int          m_idx;
  logic [14:0] m_pend;
  logic        m_conf;
  logic [31:0] m_rd;

  always @(posedge clk or negedge rst_n) begin : mdl
    int ws; bit ok; logic [14:0] cm;
    if (!rst_n) begin
      for (int i = 0; i < 135; i++) begin m_sh[i] = 0; m_ac[i] = 0; end
      m_idx = 0; m_pend = 0; m_conf = 0; m_rd = 0;
    end else begin
      ok = sw_data_we && (m_idx < 135);
      ws = m_idx / 9;
      cm = (blk_upd && !upd_lock) ? m_pend : 15'd0;
      if (hw_rd_en)
        m_rd = (hw_rd_slot < 15 && hw_rd_word < 9) ? m_ac[hw_rd_slot*9 + hw_rd_word] : 32'd0;
      if (ok && ((hw_rd_en && hw_rd_slot == ws) || cm[ws])) m_conf = 1;
      else if (sw_conf_clr) m_conf = 0;
      for (int s = 0; s < 15; s++)
        if (cm[s]) for (int w = 0; w < 9; w++) m_ac[s*9+w] = m_sh[s*9+w];
      if (ok) m_sh[m_idx] = sw_data_wdata;
      if (sw_idx_we) m_idx = sw_idx_wdata;
      else if (ok) m_idx = m_idx + 1;
      m_pend = (m_pend & ~cm) | (sw_upd_we ? sw_upd_wdata : 15'd0);
    end
  end

  task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", t, what, act, exp);
    end
  endtask

  // Compare against model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag, "sw_idx", {24'd0, sw_idx}, m_idx[31:0]);
      chk(tag, "sw_upd_pend", {17'd0, sw_upd_pend}, {17'd0, m_pend});
      chk(tag, "conflict", {31'd0, conflict}, {31'd0, m_conf});
      chk(tag, "hw_rd_data", hw_rd_data, m_rd);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected <150000", cyc);
      finish_run();
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic clr_in();
    sw_idx_we = 0; sw_data_we = 0; sw_upd_we = 0; sw_conf_clr = 0; blk_upd = 0;
    hw_rd_en = 0; sw_idx_wdata = 0; sw_data_wdata = 0; sw_upd_wdata = 0;
    hw_rd_slot = 0; hw_rd_word = 0;
  endtask
  task automatic set_idx(input int v); sw_idx_we = 1; sw_idx_wdata = 8'(v); step(); sw_idx_we = 0; endtask
  task automatic wr(input logic [31:0] d); sw_data_we = 1; sw_data_wdata = d; step(); sw_data_we = 0; endtask
  task automatic req(input logic [14:0] m); sw_upd_we = 1; sw_upd_wdata = m; step(); sw_upd_we = 0; endtask
  task automatic pulse(); blk_upd = 1; step(); blk_upd = 0; endtask
  task automatic rd(input int s, input int w); hw_rd_en = 1; hw_rd_slot = 4'(s); hw_rd_word = 4'(w); step(); hw_rd_en = 0; endtask

  initial begin
    rst_n = 0; upd_lock = 0; clr_in();
    repeat (3) step();
    rst_n = 1; step();
    // R1: reset state
    chk("R1", "idx", {24'd0, sw_idx}, 0);
    chk("R1", "pend", {17'd0, sw_upd_pend}, 0);
    rd(14, 8); chk("R1", "active word", hw_rd_data, 0);

    // R2/R3/R5: load slot 2 header + payload
    tag = "R3";
    set_idx(18); chk("R2", "idx load", {24'd0, sw_idx}, 18);
    wr({8'h44, 8'h33, 8'h22, 8'h11});
    for (int w = 1; w < 9; w++) wr(32'hA000_0000 + w);
    chk("R3", "idx after 9 writes", {24'd0, sw_idx}, 27);
    tag = "R6"; rd(2, 0); chk("R6", "shadow hidden", hw_rd_data, 0);

    // R8: lock holds the request
    tag = "R8"; req(15'h0004); upd_lock = 1; pulse(); pulse(); upd_lock = 0;
    chk("R8", "pend kept", {17'd0, sw_upd_pend}, 32'h4);
    rd(2, 0); chk("R8", "active unchanged", hw_rd_data, 0);
    repeat (3) step();
    chk("R8", "pend kept no pulse", {17'd0, sw_upd_pend}, 32'h4);

    // R7/R5: commit and read back
    tag = "R7"; pulse(); chk("R7", "pend cleared", {17'd0, sw_upd_pend}, 0);
    tag = "R5"; rd(2, 0);
    chk("R5", "byte0", {24'd0, hw_rd_data[7:0]}, 32'h11);
    chk("R5", "byte3", {24'd0, hw_rd_data[31:24]}, 32'h44);
    for (int w = 1; w < 9; w++) begin rd(2, w); chk("R5", "payload", hw_rd_data, 32'hA000_0000 + w); end

    // R4: out-of-range index
    tag = "R4"; set_idx(134); wr(32'h1234_5678); chk("R4", "idx at end", {24'd0, sw_idx}, 135);
    wr(32'hDEAD_BEEF); chk("R4", "idx held", {24'd0, sw_idx}, 135);
    set_idx(200); wr(32'hDEAD_BEEF); chk("R4", "idx held 200", {24'd0, sw_idx}, 200);
    req(15'h4000); pulse(); rd(14, 8); chk("R4", "slot14 last", hw_rd_data, 32'h1234_5678);
    rd(0, 0); chk("R4", "slot0 untouched", hw_rd_data, 0);

    // R9: invalid reads and read during commit
    tag = "R9"; rd(15, 0); chk("R9", "bad slot", hw_rd_data, 0);
    rd(2, 9); chk("R9", "bad word", hw_rd_data, 0);
    set_idx(18); wr(32'h5555_5555); req(15'h0004);
    hw_rd_en = 1; hw_rd_slot = 2; hw_rd_word = 0; blk_upd = 1; step(); blk_upd = 0; hw_rd_en = 0;
    chk("R9", "read in commit", hw_rd_data, 32'h4433_2211);

    // R10: conflicts
    tag = "R10"; set_idx(9);
    hw_rd_en = 1; hw_rd_slot = 1; sw_data_we = 1; sw_data_wdata = 32'h7; step(); clr_in();
    chk("R10", "read conflict", {31'd0, conflict}, 1);
    step(); chk("R10", "sticky", {31'd0, conflict}, 1);
    sw_conf_clr = 1; step(); sw_conf_clr = 0; chk("R10", "cleared", {31'd0, conflict}, 0);
    hw_rd_en = 1; hw_rd_slot = 3; sw_data_we = 1; sw_data_wdata = 32'h8; step(); clr_in();
    chk("R10", "other slot no conflict", {31'd0, conflict}, 0);
    set_idx(9); hw_rd_en = 1; hw_rd_slot = 1; sw_data_we = 1; sw_conf_clr = 1; step(); clr_in();
    chk("R10", "set beats clear", {31'd0, conflict}, 1);
    sw_conf_clr = 1; step(); sw_conf_clr = 0;

    // R11: commit with same-cycle write, plus commit-conflict
    tag = "R11"; set_idx(36); wr(32'h0000_00AA); req(15'h0010); set_idx(36);
    sw_data_we = 1; sw_data_wdata = 32'h0000_00BB; blk_upd = 1; step(); clr_in();
    chk("R11", "commit conflict", {31'd0, conflict}, 1);
    rd(4, 0); chk("R11", "old shadow committed", hw_rd_data, 32'hAA);
    req(15'h0010); pulse(); rd(4, 0); chk("R11", "new word later", hw_rd_data, 32'hBB);

    // R2: load and write same cycle; R7: request in commit cycle stays pending
    tag = "R2"; set_idx(45);
    sw_idx_we = 1; sw_idx_wdata = 8'd90; sw_data_we = 1; sw_data_wdata = 32'hCC; step(); clr_in();
    chk("R2", "load wins", {24'd0, sw_idx}, 90);
    tag = "R7"; req(15'h0021);
    blk_upd = 1; sw_upd_we = 1; sw_upd_wdata = 15'h0400; step(); clr_in();
    chk("R7", "new req pending", {17'd0, sw_upd_pend}, 32'h400);
    rd(5, 0); chk("R7", "slot5 committed", hw_rd_data, 32'hCC);

    // Random traffic against the model
    tag = "R7R10";
    for (int n = 0; n < 4000; n++) begin
      sw_idx_we     = ($urandom_range(0, 15) == 0);
      sw_idx_wdata  = 8'($urandom_range(0, 140));
      sw_data_we    = ($urandom_range(0, 2) == 0);
      sw_data_wdata = $urandom();
      sw_upd_we     = ($urandom_range(0, 7) == 0);
      sw_upd_wdata  = 15'($urandom());
      sw_conf_clr   = ($urandom_range(0, 9) == 0);
      blk_upd       = ($urandom_range(0, 5) == 0);
      upd_lock      = ($urandom_range(0, 3) == 0);
      hw_rd_en      = ($urandom_range(0, 1) == 0);
      hw_rd_slot    = 4'($urandom());
      hw_rd_word    = 4'($urandom_range(0, 9));
      step();
    end
    clr_in(); upd_lock = 0; step();
    finish_run();
  end
endmodule